// File: doc/BRIEF.md
# 4B5B Transmit Framing Encoder

This block sits between a MAC-style nibble interface and the line-coding stages of a 100 Mb/s transmit path. Each clock it takes one 4-bit nibble, a transmit-enable level and a transmit-error flag. Each clock it also delivers one 5-bit code group. When a frame begins, the first preamble byte (two nibbles) is replaced by the start-of-stream pair. Data nibbles after that are mapped through the fixed 4B/5B table. When transmit enable falls, the block appends the end-of-stream pair and then sends idle until the next frame.

The transmit-error flag swaps the halt code in for a data code during a frame. A bypass control sends a raw 5-bit input straight to the output for repeater-style use. While bypass is high the framing state machine is held in its idle state. Every output code group is registered, so it appears one clock after the inputs that produced it.

Top module: `tx4b5b_encoder`

## Requirements
- R1: During reset and in the first cycle after it, `cg_out` is the idle code 11111.
- R2: While `tx_en` is low and no frame is closing, `cg_out` stays at idle 11111, whatever `txd` and `tx_er` hold.
- R3: In the cycle where `tx_en` is first seen high, the code produced is J (11000) in place of that nibble. The next nibble is replaced by K (10001). `tx_er` has no effect on these two codes.
- R4: After J and K, each nibble sampled with `tx_en` high and `tx_er` low is coded as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: A data-phase nibble sampled with `tx_er` high is coded as the halt code 00100, whatever its value.
- R6: In the first cycle `tx_en` is seen low after a frame, the code produced is T (01101). The next code is R (00111). After that the output is idle while `tx_en` stays low.
- R7: If `tx_en` is high again in the cycle that produces R, R is still sent. The output then goes J and K, and data codes follow.
- R8: Each code group appears on `cg_out` after the rising clock edge that samples its inputs, not before. This is one cycle of latency.
- R9: While `bypass` is high, `cg_out` takes the value of `raw_cg` sampled at the same edge, and `tx_en` has no effect. If `tx_en` is high when `bypass` is released, a new frame starts with J.
- R10: A frame whose `tx_en` is high for only one cycle produces J, then T, R and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable, high for the whole frame |
| tx_er | input | 1 | Transmit error for the current nibble |
| txd | input | 4 | Transmit nibble |
| bypass | input | 1 | Pass `raw_cg` straight through |
| raw_cg | input | 5 | Raw code group used while bypassing |
| cg_out | output | 5 | Registered output code group |

## Verification
The data phase is driven with all sixteen nibble values in one frame. This separates any two table entries that have been swapped or mistyped. Frames of several lengths are tested:
- one nibble, which checks the early T;
- a normal frame;
- back-to-back frames where enable rises again during R, which checks that the end pair finishes and the start pair is then delayed.

An error pulse mid-frame, together with error asserted during the start pair, shows that halt replaces only data codes. Bypass runs use raw values that look like control codes while `tx_en` toggles. This shows that the framing logic neither leaks into the output nor resumes in the wrong state when bypass is released.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;

  parameter int NIB_W = 4;
  parameter int CG_W  = 5;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [CG_W-1:0]  cg_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_SSD1 = 5'b11000;
  localparam cg_t CG_SSD2 = 5'b10001;
  localparam cg_t CG_ESD1 = 5'b01101;
  localparam cg_t CG_ESD2 = 5'b00111;
  localparam cg_t CG_HALT = 5'b00100;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_SSD1,
    FR_SSD2,
    FR_DATA,
    FR_ESD2
  } frame_st_e;

  typedef enum logic [2:0] {
    EM_IDLE,
    EM_SSD1,
    EM_SSD2,
    EM_DATA,
    EM_HALT,
    EM_ESD1,
    EM_ESD2
  } emit_e;

  function automatic cg_t nib_to_cg(nib_t n);
    cg_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction

  function automatic cg_t ctrl_to_cg(emit_e e);
    cg_t c;
    case (e)
      EM_SSD1: c = CG_SSD1;
      EM_SSD2: c = CG_SSD2;
      EM_HALT: c = CG_HALT;
      EM_ESD1: c = CG_ESD1;
      EM_ESD2: c = CG_ESD2;
      default: c = CG_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tx4b5b_cgmap.sv
module tx4b5b_cgmap
  import tx4b5b_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [CG_W-1:0]  data_cg
);
  assign data_cg = nib_to_cg(nib);
endmodule

// File: rtl/tx4b5b_frame_fsm.sv
module tx4b5b_frame_fsm
  import tx4b5b_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_en,
  input  logic  tx_er,
  input  logic  bypass,
  output emit_e emit,
  output logic  ev_sof,
  output logic  ev_eof
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    emit = EM_IDLE;
    case (st_q)
      FR_IDLE: begin
        if (tx_en) begin
          emit = EM_SSD1;
          st_d = FR_SSD2;
        end
      end
      FR_SSD1: begin
        emit = EM_SSD1;
        st_d = FR_SSD2;
      end
      FR_SSD2: begin
        if (tx_en) begin
          emit = EM_SSD2;
          st_d = FR_DATA;
        end else begin
          emit = EM_ESD1;
          st_d = FR_ESD2;
        end
      end
      FR_DATA: begin
        if (tx_en) begin
          emit = tx_er ? EM_HALT : EM_DATA;
        end else begin
          emit = EM_ESD1;
          st_d = FR_ESD2;
        end
      end
      FR_ESD2: begin
        emit = EM_ESD2;
        st_d = tx_en ? FR_SSD1 : FR_IDLE;
      end
      default: st_d = FR_IDLE;
    endcase
    if (bypass) st_d = FR_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FR_IDLE;
    else        st_q <= st_d;
  end

  assign ev_sof = (emit == EM_SSD1);
  assign ev_eof = (emit == EM_ESD1);
endmodule

// File: rtl/tx4b5b_encoder.sv
module tx4b5b_encoder
  import tx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  input  logic             bypass,
  input  logic [CG_W-1:0]  raw_cg,
  output logic [CG_W-1:0]  cg_out
);
  emit_e            emit;
  logic             ev_sof;
  logic             ev_eof;
  logic [CG_W-1:0]  data_cg;
  logic [CG_W-1:0]  framed_cg;
  logic [CG_W-1:0]  cg_d;

  tx4b5b_frame_fsm i_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .tx_er  (tx_er),
    .bypass (bypass),
    .emit   (emit),
    .ev_sof (ev_sof),
    .ev_eof (ev_eof)
  );

  tx4b5b_cgmap i_map (
    .nib     (txd),
    .data_cg (data_cg)
  );

  assign framed_cg = (emit == EM_DATA) ? data_cg : ctrl_to_cg(emit);
  assign cg_d      = bypass ? raw_cg : framed_cg;

  always_ff @(posedge clk) begin
    if (!rst_n) cg_out <= CG_IDLE;
    else        cg_out <= cg_d;
  end
endmodule

// File: rtl/tx4b5b_encoder_chk.sv
module tx4b5b_encoder_chk
  import tx4b5b_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             bypass,
  input logic [CG_W-1:0]  raw_cg,
  input logic [CG_W-1:0]  cg_out
);
  logic byp_d;
  always_ff @(posedge clk) begin
    if (!rst_n) byp_d <= 1'b0;
    else        byp_d <= bypass;
  end

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_out == CG_IDLE && !byp_d && !bypass && !tx_en) |=> (cg_out == CG_IDLE));

  // R3
  ssd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_out == CG_SSD1 && !byp_d && !bypass) |=> (cg_out == CG_SSD2 || cg_out == CG_ESD1));

  // R6
  esd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_out == CG_ESD1 && !byp_d && !bypass) |=> (cg_out == CG_ESD2));

  // R7
  after_esd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cg_out == CG_ESD2 && !byp_d && !bypass) |=> (cg_out == CG_IDLE || cg_out == CG_SSD1));

  // R9
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (cg_out == $past(raw_cg)));
endmodule

bind tx4b5b_encoder tx4b5b_encoder_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tx_en  (tx_en),
  .bypass (bypass),
  .raw_cg (raw_cg),
  .cg_out (cg_out)
);

// File: tb/test_tx4b5b_encoder.sv
`timescale 1ns/1ps
module test_tx4b5b_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       bypass = 1'b0;
  logic [4:0] raw_cg = 5'h0;
  logic [4:0] cg_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // table in nibble order F..0, five bits each
  localparam logic [79:0] TBL = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};
  localparam logic [4:0] I_C = 5'b11111, J_C = 5'b11000, K_C = 5'b10001;
  localparam logic [4:0] T_C = 5'b01101, R_C = 5'b00111, H_C = 5'b00100;

  function automatic logic [4:0] exp_data(logic [3:0] n);
    return TBL[n*5 +: 5];
  endfunction

  always #5 clk = ~clk;

  tx4b5b_encoder i_tx4b5b_encoder (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .bypass(bypass), .raw_cg(raw_cg), .cg_out(cg_out));

  task automatic check(string req, logic [4:0] exp);
    vectors++;
    if (cg_out !== exp) begin
      miscompares++;
      $display("FAIL %s: cg_out=%b expected=%b at %0t", req, cg_out, exp, $time);
    end
  endtask

  task automatic step(logic en, logic er, logic [3:0] d, logic [4:0] exp, string req);
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d; bypass = 1'b0;
    @(posedge clk); #1;
    check(req, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tx_en = 1'b1; txd = 4'h7;
    repeat (3) @(posedge clk);
    #1 check("R1", I_C);
    @(negedge clk); rst_n = 1'b1; tx_en = 1'b0;
    #1 check("R1", I_C);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) step(1'b0, i[0], 4'(i * 3), I_C, "R2");
  endtask

  task automatic t_full_frame();
    step(1'b1, 1'b0, 4'h5, J_C, "R3");
    step(1'b1, 1'b1, 4'h5, K_C, "R3");
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      tx_en = 1'b1; tx_er = 1'b0; txd = 4'(n);
      #1 check("R8", (n == 0) ? K_C : exp_data(4'(n - 1)));
      @(posedge clk); #1;
      check("R4", exp_data(4'(n)));
    end
    step(1'b0, 1'b0, 4'h3, T_C, "R6");
    step(1'b0, 1'b0, 4'h3, R_C, "R6");
    step(1'b0, 1'b0, 4'h3, I_C, "R6");
  endtask

  task automatic t_error();
    step(1'b1, 1'b1, 4'h5, J_C, "R3");
    step(1'b1, 1'b0, 4'hD, K_C, "R3");
    step(1'b1, 1'b0, 4'h9, exp_data(4'h9), "R4");
    step(1'b1, 1'b1, 4'h9, H_C, "R5");
    step(1'b1, 1'b1, 4'h0, H_C, "R5");
    step(1'b1, 1'b0, 4'h0, exp_data(4'h0), "R5");
    step(1'b0, 1'b1, 4'h0, T_C, "R6");
    step(1'b0, 1'b0, 4'h0, R_C, "R6");
    step(1'b0, 1'b0, 4'h0, I_C, "R6");
  endtask

  task automatic t_back_to_back();
    step(1'b1, 1'b0, 4'h5, J_C, "R3");
    step(1'b1, 1'b0, 4'h5, K_C, "R3");
    step(1'b1, 1'b0, 4'hA, exp_data(4'hA), "R4");
    step(1'b0, 1'b0, 4'hA, T_C, "R7");
    step(1'b1, 1'b0, 4'h5, R_C, "R7");
    step(1'b1, 1'b0, 4'h5, J_C, "R7");
    step(1'b1, 1'b0, 4'h5, K_C, "R7");
    step(1'b1, 1'b0, 4'h6, exp_data(4'h6), "R7");
    step(1'b0, 1'b0, 4'h0, T_C, "R6");
    step(1'b0, 1'b0, 4'h0, R_C, "R6");
    step(1'b0, 1'b0, 4'h0, I_C, "R6");
  endtask

  task automatic t_short();
    step(1'b1, 1'b0, 4'h5, J_C, "R10");
    step(1'b0, 1'b0, 4'h5, T_C, "R10");
    step(1'b0, 1'b0, 4'h5, R_C, "R10");
    step(1'b0, 1'b0, 4'h5, I_C, "R10");
  endtask

  task automatic t_bypass();
    logic [4:0] raws [5] = '{T_C, J_C, 5'b00000, H_C, 5'b10101};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bypass = 1'b1; raw_cg = raws[i]; tx_en = i[0]; txd = 4'h2;
      @(posedge clk); #1;
      check("R9", raws[i]);
    end
    @(negedge clk);
    bypass = 1'b0; tx_en = 1'b1; txd = 4'h5;
    @(posedge clk); #1;
    check("R9", J_C);
    step(1'b1, 1'b0, 4'h5, K_C, "R9");
    step(1'b1, 1'b0, 4'hF, exp_data(4'hF), "R9");
    step(1'b0, 1'b0, 4'h0, T_C, "R9");
    step(1'b0, 1'b0, 4'h0, R_C, "R9");
    step(1'b0, 1'b0, 4'h0, I_C, "R9");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_full_frame();
    t_idle();
    t_error();
    t_back_to_back();
    t_short();
    t_bypass();
    t_idle();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule